// File: doc/BRIEF.md
# Dual Bulk Packet Buffer with Ping-Pong Linking

This block holds two byte buffers of `DEPTH` bytes each, 64 by default, that sit between a USB function's packet engine and the firmware or data-moving engine behind it. In separate mode, buffer 0 queues data for the bulk IN endpoint (endpoint 1) and buffer 1 collects data from the bulk OUT endpoint (endpoint 2). In linked mode the two buffers form a ping-pong pair. That pair serves either the IN endpoint or the OUT endpoint, chosen by a direction bit. Buffer 0 always carries DATA0 packets and buffer 1 carries DATA1 packets.

The firmware side has push and pop ports, a selector for the buffer to use, strobes that mark buffers ready, a zero-length-packet request, a receive-disable level, buffer reset strobes and write-1-to-clear event flags. The packet side is abstract. The engine can read the answer the block would give to an IN token at any time. It captures that answer with `in_req`, pops the payload bytes and confirms the handshake with `in_ack`. For an OUT packet, `out_ack` tells the engine whether the data is accepted. An accepted packet is bracketed by `out_start` and `out_end`, with the bytes written in between.

Top module: `bulk_pp_buf`

## Requirements
- R1: `max_len` always reads `DEPTH`. A buffer never holds more than `DEPTH` bytes, and a push into a full buffer is dropped with no change to its count.
- R2: With the link bit clear, firmware selector value 0 addresses the IN buffer and value 1 addresses the OUT buffer. An accepted OUT packet first empties buffer 1, then fills it, and never touches buffer 0.
- R3: With the link bit set, direction 0 makes both buffers serve IN and direction 1 makes both serve OUT. Traffic toward the endpoint the pair does not serve gets NAK. The pair starts at buffer 0 and then alternates strictly, switching after each completed data packet. If the buffer whose turn it is is not ready, the answer is NAK, whatever the state of the other buffer. The `in_resp` encoding is 0 = NAK, 1 = data (length on `in_len`), 2 = zero-length packet.
- R4: A configuration write that arrives while the link bit is set leaves the direction unchanged. The direction takes a new value only from a write made while the link bit is clear.
- R5: `rdy_set` bit n sets the ready bit of buffer n. That bit is cleared when a data packet from buffer n completes: `in_ack` for IN, or `out_end` in linked OUT mode. In separate mode, ready bit 0 gates transmission from buffer 0.
- R6: With full-packet-only set, a ready buffer holding fewer than `DEPTH` bytes is answered with NAK and stays ready. A full buffer is sent.
- R7: `null_set` makes the IN answer a zero-length packet, which takes priority over ready data. The request clears when that packet's `in_ack` arrives and leaves the ready bits and alternation unchanged.
- R8: While `rx_dis` is high, `out_ack` is low. OUT traffic changes neither the buffer contents, the count nor `rx_len`.
- R9: `tx_rst` empties the IN-side buffers and clears their ready bits. `rx_rst` does the same for the OUT-side buffers. Each also sends the alternation back to buffer 0 when it applies to the linked pair.
- R10: `flags_o[0]` is set by a completed IN packet and `flags_o[1]` by a completed OUT packet. `rx_len` holds the byte count of the last completed OUT packet. Writing 1 to a bit of `flag_clr` clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_link | input | 1 | Link bit value to write |
| cfg_dir | input | 1 | Link direction value to write (0 IN, 1 OUT) |
| cfg_full_only | input | 1 | Full-packet-only value to write |
| rdy_set | input | 2 | Ready-set strobes, one per buffer |
| null_set | input | 1 | Request one zero-length IN packet |
| rx_dis | input | 1 | Receive disable level |
| tx_rst | input | 1 | Empty the IN-side buffers |
| rx_rst | input | 1 | Empty the OUT-side buffers |
| flag_clr | input | 2 | Write-1-to-clear for the event flags |
| fw_sel | input | 1 | Buffer addressed by the firmware ports |
| fw_wr | input | 1 | Firmware push strobe |
| fw_wdata | input | 8 | Firmware push data |
| fw_rd | input | 1 | Firmware pop strobe |
| fw_rdata | output | 8 | Head byte of the selected buffer |
| in_req | input | 1 | IN token: capture the current answer |
| in_rd | input | 1 | Pop one byte of the IN packet in flight |
| in_ack | input | 1 | Host handshake for the IN packet in flight |
| in_resp | output | 2 | Current IN answer (0 NAK, 1 data, 2 zero-length) |
| in_len | output | CW | Length the IN answer would carry |
| in_rdata | output | 8 | Head byte of the buffer being sent |
| out_start | input | 1 | Start of an OUT packet |
| out_wr | input | 1 | OUT payload byte strobe |
| out_wdata | input | 8 | OUT payload byte |
| out_end | input | 1 | End of a good OUT packet |
| out_ack | output | 1 | OUT would be accepted (0 means NAK) |
| link_o | output | 1 | Current link bit |
| dir_o | output | 1 | Current link direction |
| rdy_o | output | 2 | Ready bits |
| null_o | output | 1 | Zero-length request pending |
| flags_o | output | 2 | Event flags: bit 0 IN done, bit 1 OUT done |
| rx_len | output | CW | Length of the last completed OUT packet |
| cnt0 | output | CW | Bytes held in buffer 0 |
| cnt1 | output | CW | Bytes held in buffer 1 |
| max_len | output | CW | Constant buffer capacity |

## Verification
The bench builds the block with `DEPTH` = 8, so CW = 4. At that size it can sweep every packet length from empty to full in both directions, with full-packet-only both off and on. The small depth also brings the full-buffer boundary and the dropped ninth push within a few cycles. Linked mode is driven in both directions to check the strict buffer-0-first alternation, NAK on an out-of-turn ready buffer, and a blocked direction change. Expected bytes follow an arithmetic pattern derived from the packet length and byte index.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    typedef enum logic [1:0] {
        IK_NAK  = 2'd0,
        IK_DATA = 2'd1,
        IK_ZLP  = 2'd2
    } in_kind_e;

    // Does buffer idx belong to the IN side under this configuration?
    function automatic logic in_owns(input logic link, input logic dir, input logic idx);
        return link ? !dir : (idx == 1'b0);
    endfunction

    // Does buffer idx belong to the OUT side under this configuration?
    function automatic logic out_owns(input logic link, input logic dir, input logic idx);
        return link ? dir : (idx == 1'b1);
    endfunction

endpackage

// File: rtl/bpp_store.sv
module bpp_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] head,
    output logic [CW-1:0] cnt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_ok = wr && (cnt < CW'(DEPTH));
    assign rd_ok = rd && (cnt != '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok && !clr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= step(wp);
            if (rd_ok) rp <= step(rp);
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/bpp_pick.sv
module bpp_pick
    import bpp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          in_ep,
    input  logic          null_p,
    input  logic          rdy,
    input  logic          full_only,
    input  logic [CW-1:0] cnt,
    output in_kind_e      kind,
    output logic [CW-1:0] len
);
    always_comb begin
        kind = IK_NAK;
        len  = '0;
        if (in_ep) begin
            if (null_p) begin
                kind = IK_ZLP;
            end else if (rdy && (!full_only || cnt == CW'(DEPTH))) begin
                kind = IK_DATA;
                len  = cnt;
            end
        end
    end
endmodule

// File: rtl/bulk_pp_buf.sv
module bulk_pp_buf
    import bpp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_link,
    input  logic          cfg_dir,
    input  logic          cfg_full_only,
    input  logic [1:0]    rdy_set,
    input  logic          null_set,
    input  logic          rx_dis,
    input  logic          tx_rst,
    input  logic          rx_rst,
    input  logic [1:0]    flag_clr,
    input  logic          fw_sel,
    input  logic          fw_wr,
    input  logic [DW-1:0] fw_wdata,
    input  logic          fw_rd,
    output logic [DW-1:0] fw_rdata,
    input  logic          in_req,
    input  logic          in_rd,
    input  logic          in_ack,
    output logic [1:0]    in_resp,
    output logic [CW-1:0] in_len,
    output logic [DW-1:0] in_rdata,
    input  logic          out_start,
    input  logic          out_wr,
    input  logic [DW-1:0] out_wdata,
    input  logic          out_end,
    output logic          out_ack,
    output logic          link_o,
    output logic          dir_o,
    output logic [1:0]    rdy_o,
    output logic          null_o,
    output logic [1:0]    flags_o,
    output logic [CW-1:0] rx_len,
    output logic [CW-1:0] cnt0,
    output logic [CW-1:0] cnt1,
    output logic [CW-1:0] max_len
);
    logic          link_q, dir_q, fonly_q, null_q, tog_q;
    logic [1:0]    rdy_q, flags_q;
    logic          tx_act, txb_q, rx_act, rxb_q;
    in_kind_e      txk_q, kind;
    logic [CW-1:0] rxlen_q, pick_len;
    logic [CW-1:0] cnt  [2];
    logic [DW-1:0] head [2];
    logic          in_ep, out_ep, ib, ob, rx_take;

    assign in_ep   = !link_q || !dir_q;
    assign out_ep  = !link_q || dir_q;
    assign ib      = link_q ? tog_q : 1'b0;
    assign ob      = link_q ? tog_q : 1'b1;
    assign out_ack = out_ep && !rx_dis && !rx_act && (!link_q || rdy_q[ob]);
    assign rx_take = out_start && out_ack;

    bpp_pick #(.DEPTH(DEPTH)) u_pick (
        .in_ep     (in_ep),
        .null_p    (null_q),
        .rdy       (rdy_q[ib]),
        .full_only (fonly_q),
        .cnt       (cnt[ib]),
        .kind      (kind),
        .len       (pick_len)
    );

    for (genvar g = 0; g < 2; g++) begin : g_buf
        localparam logic IDX = 1'(g);
        logic          b_wr, b_rd, b_clr;
        logic [DW-1:0] b_wdata;
        assign b_wr    = (fw_wr && fw_sel == IDX) || (rx_act && out_wr && rxb_q == IDX);
        assign b_wdata = (rx_act && rxb_q == IDX) ? out_wdata : fw_wdata;
        assign b_rd    = (fw_rd && fw_sel == IDX) || (tx_act && in_rd && txb_q == IDX);
        assign b_clr   = (tx_rst && in_owns(link_q, dir_q, IDX))
                       || (rx_rst && out_owns(link_q, dir_q, IDX))
                       || (rx_take && ob == IDX);
        bpp_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
            .clk   (clk),
            .rst   (rst),
            .clr   (b_clr),
            .wr    (b_wr),
            .wdata (b_wdata),
            .rd    (b_rd),
            .head  (head[g]),
            .cnt   (cnt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q  <= 1'b0;
            dir_q   <= 1'b0;
            fonly_q <= 1'b0;
            null_q  <= 1'b0;
            tog_q   <= 1'b0;
            rdy_q   <= '0;
            flags_q <= '0;
            tx_act  <= 1'b0;
            txb_q   <= 1'b0;
            txk_q   <= IK_NAK;
            rx_act  <= 1'b0;
            rxb_q   <= 1'b0;
            rxlen_q <= '0;
        end else begin
            if (cfg_we) begin
                link_q  <= cfg_link;
                fonly_q <= cfg_full_only;
                if (!link_q) dir_q <= cfg_dir;
                tog_q   <= 1'b0;
            end
            if (null_set) null_q <= 1'b1;
            rdy_q   <= rdy_q | rdy_set;
            flags_q <= flags_q & ~flag_clr;

            for (int i = 0; i < 2; i++) begin
                if (tx_rst && in_owns(link_q, dir_q, 1'(i)))  rdy_q[i] <= 1'b0;
                if (rx_rst && out_owns(link_q, dir_q, 1'(i))) rdy_q[i] <= 1'b0;
            end
            if (link_q && ((tx_rst && !dir_q) || (rx_rst && dir_q))) tog_q <= 1'b0;

            if (in_req && !tx_act) begin
                tx_act <= (kind != IK_NAK);
                txb_q  <= ib;
                txk_q  <= kind;
            end
            if (in_ack && tx_act) begin
                tx_act     <= 1'b0;
                flags_q[0] <= 1'b1;
                if (txk_q == IK_ZLP) begin
                    null_q <= 1'b0;
                end else begin
                    rdy_q[txb_q] <= 1'b0;
                    if (link_q) tog_q <= ~tog_q;
                end
            end

            if (rx_take) begin
                rx_act <= 1'b1;
                rxb_q  <= ob;
            end
            if (out_end && rx_act) begin
                rx_act     <= 1'b0;
                flags_q[1] <= 1'b1;
                rxlen_q    <= cnt[rxb_q];
                if (link_q) begin
                    rdy_q[rxb_q] <= 1'b0;
                    tog_q        <= ~tog_q;
                end
            end
        end
    end

    assign fw_rdata = head[fw_sel];
    assign in_rdata = head[txb_q];
    assign in_resp  = kind;
    assign in_len   = pick_len;
    assign link_o   = link_q;
    assign dir_o    = dir_q;
    assign rdy_o    = rdy_q;
    assign null_o   = null_q;
    assign flags_o  = flags_q;
    assign rx_len   = rxlen_q;
    assign cnt0     = cnt[0];
    assign cnt1     = cnt[1];
    assign max_len  = CW'(DEPTH);
endmodule

// File: rtl/bulk_pp_chk.sv
module bulk_pp_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          link_o,
    input logic          dir_o,
    input logic          rx_dis,
    input logic          out_ack,
    input logic          null_o,
    input logic          in_ack,
    input logic [1:0]    in_resp,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1
);
    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && link_o) |=> (dir_o == $past(dir_o)));

    // R8
    rxdis_nak_chk: assert property (@(posedge clk) disable iff (rst)
        rx_dis |-> !out_ack);

    // R1
    cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

    // R7
    null_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(null_o) |-> $past(in_ack));

    // R7
    zlp_first_chk: assert property (@(posedge clk) disable iff (rst)
        (null_o && (!link_o || !dir_o)) |-> (in_resp == 2'd2));
endmodule

bind bulk_pp_buf bulk_pp_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/sim_bulk_pp_buf.sv
module sim_bulk_pp_buf;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic clk = 0, rst = 1;
    logic cfg_we = 0, cfg_link = 0, cfg_dir = 0, cfg_full_only = 0;
    logic [1:0] rdy_set = 0, flag_clr = 0;
    logic null_set = 0, rx_dis = 0, tx_rst = 0, rx_rst = 0;
    logic fw_sel = 0, fw_wr = 0, fw_rd = 0;
    logic [7:0] fw_wdata = 0, out_wdata = 0;
    logic in_req = 0, in_rd = 0, in_ack = 0;
    logic out_start = 0, out_wr = 0, out_end = 0;
    logic [7:0] fw_rdata, in_rdata;
    logic [1:0] in_resp, rdy_o, flags_o;
    logic [CW-1:0] in_len, rx_len, cnt0, cnt1, max_len;
    logic out_ack, link_o, dir_o, null_o;
    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    bulk_pp_buf #(.DEPTH(D)) u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic l, input logic d, input logic f);
        cfg_link = l; cfg_dir = d; cfg_full_only = f; cfg_we = 1;
        @(negedge clk); cfg_we = 0; #1;
    endtask

    task automatic push(input logic s, input int v);
        fw_sel = s; fw_wdata = 8'(v); fw_wr = 1;
        @(negedge clk); fw_wr = 0; #1;
    endtask

    task automatic fwpop(input logic s, input int exp, input string tag);
        fw_sel = s; #1;
        chk(tag, fw_rdata, exp & 255);
        fw_rd = 1; @(negedge clk); fw_rd = 0; #1;
    endtask

    task automatic ready(input logic [1:0] m);
        rdy_set = m; @(negedge clk); rdy_set = 0; #1;
    endtask

    task automatic fclr(input logic [1:0] m);
        flag_clr = m; @(negedge clk); flag_clr = 0; #1;
    endtask

    task automatic pulse_txrst;
        tx_rst = 1; @(negedge clk); tx_rst = 0; #1;
    endtask

    task automatic pulse_rxrst;
        rx_rst = 1; @(negedge clk); rx_rst = 0; #1;
    endtask

    task automatic in_packet(input int kind, input int len, input int base, input string tag);
        chk({tag, " kind"}, in_resp, kind);
        if (kind == 1) chk({tag, " len"}, in_len, len);
        in_req = 1; @(negedge clk); in_req = 0; #1;
        if (kind != 0) begin
            for (int j = 0; j < len; j++) begin
                chk({tag, " byte"}, in_rdata, (base + j) & 255);
                in_rd = 1; @(negedge clk); in_rd = 0; #1;
            end
            in_ack = 1; @(negedge clk); in_ack = 0; #1;
        end
    endtask

    task automatic out_packet(input int acc, input int len, input int base, input string tag);
        chk({tag, " ack"}, out_ack, acc);
        out_start = 1; @(negedge clk); out_start = 0; #1;
        for (int j = 0; j < len; j++) begin
            out_wdata = 8'(base + j); out_wr = 1;
            @(negedge clk); out_wr = 0; #1;
        end
        out_end = 1; @(negedge clk); out_end = 0; #1;
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; #1;
        // reset state
        chk("R1 max_len", max_len, D);
        chk("R5 rdy reset", rdy_o, 0);
        chk("R10 flags reset", flags_o, 0);
        chk("R3 resp reset", in_resp, 0);
        chk("R1 cnt reset", cnt0 + cnt1, 0);

        // R2 R6 R5 R10 separate-mode IN sweep over every length
        for (int fo = 0; fo < 2; fo++) begin
            for (int n = 0; n <= D; n++) begin
                cfg(0, 0, 1'(fo));
                for (int j = 0; j < n; j++) push(0, n * 16 + j);
                chk("R1 fill", cnt0, n);
                ready(2'b01);
                if (fo == 1 && n < D) begin
                    in_packet(0, 0, 0, "R6 short nak");
                    chk("R6 stays ready", rdy_o[0], 1);
                    pulse_txrst;
                    chk("R9 tx cnt", cnt0, 0);
                    chk("R9 tx rdy", rdy_o[0], 0);
                end else begin
                    in_packet(1, n, n * 16, "R2 in data");
                    chk("R5 rdy cleared", rdy_o[0], 0);
                    chk("R10 tx flag", flags_o[0], 1);
                    fclr(2'b01);
                    chk("R10 tx flag w1c", flags_o[0], 0);
                end
            end
        end

        // R1 overflow
        cfg(0, 0, 0);
        for (int j = 0; j <= D; j++) push(0, 200 + j);
        chk("R1 overflow cnt", cnt0, D);
        for (int j = 0; j < D; j++) fwpop(0, 200 + j, "R1 overflow data");
        chk("R1 drained", cnt0, 0);

        // R7 zero-length packet, priority over ready data
        for (int j = 0; j < 3; j++) push(0, 50 + j);
        ready(2'b01);
        null_set = 1; @(negedge clk); null_set = 0; #1;
        chk("R7 null pending", null_o, 1);
        in_packet(2, 0, 0, "R7 zlp");
        chk("R7 null cleared", null_o, 0);
        chk("R7 rdy kept", rdy_o[0], 1);
        in_packet(1, 3, 50, "R7 data after zlp");
        fclr(2'b11);

        // R2 R10 separate-mode OUT sweep
        for (int k = 0; k <= D; k++) begin
            out_packet(1, k, 100 + k, "R2 out");
            chk("R10 rx_len", rx_len, k);
            chk("R10 rx flag", flags_o[1], 1);
            chk("R2 out cnt1", cnt1, k);
            chk("R2 buf0 untouched", cnt0, 0);
            for (int j = 0; j < k; j++) fwpop(1, 100 + k + j, "R2 out data");
            fclr(2'b10);
            chk("R10 rx flag w1c", flags_o[1], 0);
        end

        // R8 receive disable
        out_packet(1, 3, 70, "R8 pre");
        rx_dis = 1; #1;
        out_packet(0, 2, 90, "R8 nak");
        chk("R8 cnt kept", cnt1, 3);
        chk("R8 len kept", rx_len, 3);
        fwpop(1, 70, "R8 data kept");
        rx_dis = 0; #1;
        pulse_rxrst;
        chk("R9 rx cnt", cnt1, 0);

        // R3 linked IN ping-pong
        cfg(1, 0, 0);
        chk("R3 linked", link_o, 1);
        for (int j = 0; j < 2; j++) push(0, 10 + j);
        for (int j = 0; j < 3; j++) push(1, 20 + j);
        ready(2'b10);
        chk("R3 out of turn nak", in_resp, 0);
        chk("R3 out ep blocked", out_ack, 0);
        ready(2'b01);
        in_packet(1, 2, 10, "R3 ping buf0");
        chk("R5 rdy buf0 cleared", rdy_o, 2'b10);
        in_packet(1, 3, 20, "R3 pong buf1");
        chk("R3 idle nak", in_resp, 0);
        cfg(1, 1, 0);
        chk("R4 dir ignored", dir_o, 0);

        // R3 linked OUT ping-pong
        cfg(0, 1, 0);
        cfg(1, 1, 0);
        chk("R4 dir set", dir_o, 1);
        chk("R3 in blocked", in_resp, 0);
        ready(2'b11);
        out_packet(1, 2, 30, "R3 out buf0");
        chk("R3 out cnt0", cnt0, 2);
        out_packet(1, 4, 40, "R3 out buf1");
        chk("R3 out cnt1", cnt1, 4);
        chk("R10 linked rx_len", rx_len, 4);
        chk("R5 out rdy cleared", rdy_o, 0);
        chk("R3 no ready nak", out_ack, 0);
        fwpop(0, 30, "R3 out data0");
        fwpop(1, 40, "R3 out data1");
        pulse_rxrst;
        chk("R9 linked rx cnt", cnt0 + cnt1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule